// File: doc/BRIEF.md
# Text Row Register File with Tile Loader

This block is a small register file on an 8-bit host bus. It holds the timing and scroll settings that a text display engine uses for its character rows. It also holds the mode and pattern settings that a raster-operation drawing unit uses. Six 5-bit row registers can be written and read back by the host. The first three set where the glyph scanlines start and end on the first row, and where a row blanks. The other three set the scroll amount, the row where scrolling begins and how many rows scroll. Every stored value drives a parallel output, so the display and drawing logic can use it without a bus access.

The host selects a register with address bits 3:1. Bit 0 is not decoded, so odd offsets alias the even offset below them. Offset 0xC holds the raster-op mode byte and offset 0xE is a single data port for the tile pattern. Writing the mode byte rewinds an internal tile pointer. Each write to the data port then fills the next of four tile slots, and the pointer wraps after the last slot. The mode and tile registers cannot be read, and an input that turns the raster-op feature off blocks writes to both of them.

Top module: `txtrow_regfile`

## Requirements
- R1: Synchronous active-high reset clears all six row registers, the mode byte, every tile slot and the tile pointer to zero.
- R2: A write to offset 0x0, 0x2, 0x4, 0x6, 0x8 or 0xA stores wdata[4:0] in row register 0 to 5, in that order. The stored value drives the matching row output from the next clock edge, and wdata[7:5] is dropped.
- R3: With addr[3:1] below 6, rdata combinationally returns the selected row register zero-extended: rdata[7:5] is 0 and rdata[4:0] is the stored value.
- R4: A read at offset 0xC or 0xE (addr[3:1] equal to 6 or 7) returns 8'hFF.
- R5: A write to offset 0xC with rop_allow high stores the full byte in rop_mode. rop_op carries rop_mode[7:6]: bit 1 is the unit enable, and bit 0 selects read-modify-write (1) or compare/tile mode (0).
- R6: A write to offset 0xC with rop_allow high returns the tile pointer to slot 0, so the next tile write lands in slot 0.
- R7: A write to offset 0xE with rop_allow high copies the byte into both halves of the 16-bit tile slot that the pointer selects. Slot k is tile_slots[16k+15:16k]. The pointer then steps to the next slot and goes from 3 back to 0.
- R8: While rop_allow is low, writes to offsets 0xC and 0xE change neither rop_mode, the tile slots nor the tile pointer.
- R9: Address bit 0 is ignored: an access at an odd offset behaves exactly like one at the even offset below it.
- R10: A write changes only the register its offset selects; all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rop_allow | input | 1 | Allows writes to the mode and tile registers |
| wr_en | input | 1 | Write strobe, one write per clock edge |
| addr | input | 4 | Byte offset; bits 3:1 select the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| first_start | output | 5 | Row register 0: first-row glyph start scanline |
| first_end | output | 5 | Row register 1: first-row glyph end scanline |
| blank_line | output | 5 | Row register 2: scanline at which a row blanks |
| scroll_lines | output | 5 | Row register 3: scroll amount in lines |
| scroll_base | output | 5 | Row register 4: row where scrolling starts |
| scroll_span | output | 5 | Row register 5: number of scrolled rows |
| rop_mode | output | 8 | Stored raster-op mode byte |
| rop_op | output | 2 | Operation field: {enable, read-modify-write} |
| tile_slots | output | 64 | Four 16-bit tile slots, slot 0 in the low bits |

## Verification
The assertions assume that rst is asserted at the first clock edge. They also assume that addr, wdata, wr_en and rop_allow hold steady around each rising edge, so that the value checked one cycle later is the one that was captured. The bench drives every input on the falling edge and applies reset before any write. It then sweeps all sixteen offsets with a fixed set of data bytes, once with rop_allow high and once with it low. It also runs tile write sequences that wrap the pointer and rewind it in the middle of a pass. After every write it reads back all sixteen offsets, while the clock is low.

// File: rtl/txtrow_pkg.sv
package txtrow_pkg;

  localparam int DATA_W  = 8;
  localparam int ROW_W   = 5;
  localparam int ROW_N   = 6;
  localparam int OFS_W   = 4;
  localparam int TILE_N  = 4;
  localparam int TILE_W  = 2 * DATA_W;
  localparam int SEL_W   = OFS_W - 1;
  localparam int PTR_W   = (TILE_N > 1) ? $clog2(TILE_N) : 1;
  localparam int MODE_IDX = ROW_N;
  localparam int TILE_IDX = ROW_N + 1;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [TILE_W-1:0] tile_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [SEL_W-1:0]  sel_t;

  // Register index taken from the word part of the offset
  function automatic sel_t offset_to_sel(input logic [OFS_W-1:0] ofs);
    return ofs[OFS_W-1:1];
  endfunction

  // Keep only the row-field bits of a data byte
  function automatic row_t trim_row(input byte_t b);
    return b[ROW_W-1:0];
  endfunction

  // Widen a row field back to a bus byte with zero fill
  function automatic byte_t widen_row(input row_t r);
    byte_t w;
    w = '0;
    w[ROW_W-1:0] = r;
    return w;
  endfunction

  // Tile slot content: the byte repeated into both halves
  function automatic tile_t spread_tile(input byte_t b);
    return {b, b};
  endfunction

  // Tile pointer advance with wrap after the last slot
  function automatic ptr_t ptr_step(input ptr_t p);
    if (int'(p) == TILE_N - 1) return '0;
    return p + ptr_t'(1);
  endfunction

  // Operation field: the two most significant mode bits
  function automatic logic [1:0] mode_to_op(input byte_t m);
    return m[DATA_W-1 -: 2];
  endfunction

endpackage

// File: rtl/txtrow_decode.sv
module txtrow_decode
  import txtrow_pkg::*;
#(
  parameter int P_OFS_W = OFS_W,
  parameter int P_ROW_N = ROW_N
) (
  input  logic               wr_en,
  input  logic               rop_allow,
  input  logic [P_OFS_W-1:0] addr,
  output logic [P_OFS_W-2:0] sel,
  output logic [P_ROW_N-1:0] row_we,
  output logic               mode_we,
  output logic               tile_we
);

  localparam int L_SEL_W = P_OFS_W - 1;

  logic unused_addr_lsb;
  assign unused_addr_lsb = addr[0];

  assign sel = addr[P_OFS_W-1:1];

  genvar gi;
  generate
    for (gi = 0; gi < P_ROW_N; gi++) begin : g_row_hit
      assign row_we[gi] = wr_en && (sel == L_SEL_W'(gi));
    end
  endgenerate

  assign mode_we = wr_en && rop_allow && (sel == L_SEL_W'(P_ROW_N));
  assign tile_we = wr_en && rop_allow && (sel == L_SEL_W'(P_ROW_N + 1));

endmodule

// File: rtl/txtrow_rowbank.sv
module txtrow_rowbank
  import txtrow_pkg::*;
#(
  parameter int P_ROW_N  = ROW_N,
  parameter int P_ROW_W  = ROW_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [P_ROW_N-1:0]           row_we,
  input  logic [P_DATA_W-1:0]          wdata,
  output logic [P_ROW_N*P_ROW_W-1:0]   row_flat
);

  logic [P_ROW_W-1:0] trimmed;
  logic unused_upper;

  assign trimmed      = wdata[P_ROW_W-1:0];
  assign unused_upper = ^wdata[P_DATA_W-1:P_ROW_W];

  genvar gi;
  generate
    for (gi = 0; gi < P_ROW_N; gi++) begin : g_row
      logic [P_ROW_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (row_we[gi]) begin
          q <= trimmed;
        end
      end
      assign row_flat[gi*P_ROW_W +: P_ROW_W] = q;
    end
  endgenerate

endmodule

// File: rtl/txtrow_tilebuf.sv
module txtrow_tilebuf
  import txtrow_pkg::*;
#(
  parameter int P_TILE_N = TILE_N,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              mode_we,
  input  logic                              tile_we,
  input  logic [P_DATA_W-1:0]               wdata,
  output logic [P_DATA_W-1:0]               mode_q,
  output logic [PTR_W-1:0]                  ptr_q,
  output logic [P_TILE_N*2*P_DATA_W-1:0]    tile_flat
);

  localparam int L_TW = 2 * P_DATA_W;

  logic [PTR_W-1:0] ptr_nx;

  // Mode byte
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= wdata;
    end
  end

  // Tile pointer: rewound by a mode write, stepped by a tile write
  always_comb begin
    ptr_nx = ptr_q;
    if (mode_we) begin
      ptr_nx = '0;
    end else if (tile_we) begin
      ptr_nx = ptr_step(ptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_nx;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < P_TILE_N; gi++) begin : g_slot
      logic [L_TW-1:0] slot_q;
      logic            hit;
      assign hit = tile_we && (int'(ptr_q) == gi);
      always_ff @(posedge clk) begin
        if (rst) begin
          slot_q <= '0;
        end else if (hit) begin
          slot_q <= {wdata, wdata};
        end
      end
      assign tile_flat[gi*L_TW +: L_TW] = slot_q;
    end
  endgenerate

endmodule

// File: rtl/txtrow_regfile.sv
module txtrow_regfile
  import txtrow_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ROW_W  = ROW_W,
  parameter int P_ROW_N  = ROW_N,
  parameter int P_OFS_W  = OFS_W,
  parameter int P_TILE_N = TILE_N
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rop_allow,
  input  logic                            wr_en,
  input  logic [P_OFS_W-1:0]              addr,
  input  logic [P_DATA_W-1:0]             wdata,
  output logic [P_DATA_W-1:0]             rdata,
  output logic [P_ROW_W-1:0]              first_start,
  output logic [P_ROW_W-1:0]              first_end,
  output logic [P_ROW_W-1:0]              blank_line,
  output logic [P_ROW_W-1:0]              scroll_lines,
  output logic [P_ROW_W-1:0]              scroll_base,
  output logic [P_ROW_W-1:0]              scroll_span,
  output logic [P_DATA_W-1:0]             rop_mode,
  output logic [1:0]                      rop_op,
  output logic [P_TILE_N*2*P_DATA_W-1:0]  tile_slots
);

  localparam int L_SEL_W = P_OFS_W - 1;

  // Named internal events, visible to the bound checker
  logic [L_SEL_W-1:0]          sel;
  logic [P_ROW_N-1:0]          row_we;
  logic                        mode_we;
  logic                        tile_we;
  logic [PTR_W-1:0]            tile_ptr;
  logic [P_ROW_N*P_ROW_W-1:0]  row_flat;

  txtrow_decode #(
    .P_OFS_W (P_OFS_W),
    .P_ROW_N (P_ROW_N)
  ) u_decode (
    .wr_en     (wr_en),
    .rop_allow (rop_allow),
    .addr      (addr),
    .sel       (sel),
    .row_we    (row_we),
    .mode_we   (mode_we),
    .tile_we   (tile_we)
  );

  txtrow_rowbank #(
    .P_ROW_N  (P_ROW_N),
    .P_ROW_W  (P_ROW_W),
    .P_DATA_W (P_DATA_W)
  ) u_rowbank (
    .clk      (clk),
    .rst      (rst),
    .row_we   (row_we),
    .wdata    (wdata),
    .row_flat (row_flat)
  );

  txtrow_tilebuf #(
    .P_TILE_N (P_TILE_N),
    .P_DATA_W (P_DATA_W)
  ) u_tilebuf (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (mode_we),
    .tile_we   (tile_we),
    .wdata     (wdata),
    .mode_q    (rop_mode),
    .ptr_q     (tile_ptr),
    .tile_flat (tile_slots)
  );

  // Combinational read-back: row registers zero-extended, others all ones
  always_comb begin
    rdata = '1;
    for (int i = 0; i < P_ROW_N; i++) begin
      if (sel == L_SEL_W'(i)) begin
        rdata = '0;
        rdata[P_ROW_W-1:0] = row_flat[i*P_ROW_W +: P_ROW_W];
      end
    end
  end

  assign first_start  = row_flat[0*P_ROW_W +: P_ROW_W];
  assign first_end    = row_flat[1*P_ROW_W +: P_ROW_W];
  assign blank_line   = row_flat[2*P_ROW_W +: P_ROW_W];
  assign scroll_lines = row_flat[3*P_ROW_W +: P_ROW_W];
  assign scroll_base  = row_flat[4*P_ROW_W +: P_ROW_W];
  assign scroll_span  = row_flat[5*P_ROW_W +: P_ROW_W];

  assign rop_op = mode_to_op(rop_mode);

endmodule

// File: rtl/txtrow_chk.sv
module txtrow_chk
  import txtrow_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ROW_W  = ROW_W,
  parameter int P_ROW_N  = ROW_N,
  parameter int P_OFS_W  = OFS_W,
  parameter int P_TILE_N = TILE_N
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            rop_allow,
  input logic                            wr_en,
  input logic [P_OFS_W-1:0]              addr,
  input logic [P_DATA_W-1:0]             wdata,
  input logic [P_DATA_W-1:0]             rdata,
  input logic [P_ROW_N*P_ROW_W-1:0]      row_flat,
  input logic [P_DATA_W-1:0]             rop_mode,
  input logic [PTR_W-1:0]                tile_ptr,
  input logic [P_TILE_N*2*P_DATA_W-1:0]  tile_slots
);

  localparam int L_SEL_W = P_OFS_W - 1;

  logic [L_SEL_W-1:0] idx;
  assign idx = addr[P_OFS_W-1:1];

  function automatic logic [P_ROW_W-1:0] row_at(
    input logic [P_ROW_N*P_ROW_W-1:0] f, input logic [L_SEL_W-1:0] i);
    return f[int'(i)*P_ROW_W +: P_ROW_W];
  endfunction

  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(idx) < P_ROW_N) |=>
      row_at(row_flat, $past(idx)) == $past(wdata[P_ROW_W-1:0])); // R2

  AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) < P_ROW_N) |->
      (rdata[P_DATA_W-1:P_ROW_W] == '0 && rdata[P_ROW_W-1:0] == row_at(row_flat, idx))); // R3

  AST_RD_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) >= P_ROW_N) |-> (rdata == '1)); // R4

  AST_MODE_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rop_allow && int'(idx) == P_ROW_N) |=> (rop_mode == $past(wdata))); // R5

  AST_PTR_REWIND: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rop_allow && int'(idx) == P_ROW_N) |=> (tile_ptr == '0)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rop_allow && int'(idx) == P_ROW_N + 1) |=>
      (int'(tile_ptr) == (int'($past(tile_ptr)) + 1) % P_TILE_N)); // R7

  AST_ROP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!rop_allow) |=> ($stable(rop_mode) && $stable(tile_ptr) && $stable(tile_slots))); // R8

endmodule

bind txtrow_regfile txtrow_chk #(
  .P_DATA_W (P_DATA_W),
  .P_ROW_W  (P_ROW_W),
  .P_ROW_N  (P_ROW_N),
  .P_OFS_W  (P_OFS_W),
  .P_TILE_N (P_TILE_N)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rop_allow  (rop_allow),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .row_flat   (row_flat),
  .rop_mode   (rop_mode),
  .tile_ptr   (tile_ptr),
  .tile_slots (tile_slots)
);

// File: tb/txtrow_regfile_tb.sv
`timescale 1ns/100ps
module txtrow_regfile_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        rop_allow;
  logic        wr_en;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [4:0]  first_start, first_end, blank_line;
  logic [4:0]  scroll_lines, scroll_base, scroll_span;
  logic [7:0]  rop_mode;
  logic [1:0]  rop_op;
  logic [63:0] tile_slots;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model
  logic [4:0] m_row [6];
  logic [7:0] m_mode;
  logic [7:0] m_tile [4];
  int         m_ptr;

  always #2 clk = ~clk;

  txtrow_regfile u_dut (
    .clk(clk), .rst(rst), .rop_allow(rop_allow), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .first_start(first_start), .first_end(first_end), .blank_line(blank_line),
    .scroll_lines(scroll_lines), .scroll_base(scroll_base), .scroll_span(scroll_span),
    .rop_mode(rop_mode), .rop_op(rop_op), .tile_slots(tile_slots)
  );

  task automatic expect_eq(input string req, input string what, input logic [15:0] act,
                           input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) m_row[i] = '0;
    for (int i = 0; i < 4; i++) m_tile[i] = '0;
    m_mode = '0;
    m_ptr  = 0;
  endtask

  // Requirements restated: index from offset/2, rows keep 5 bits,
  // mode rewinds pointer, tiles fill in turn, gated by rop_allow
  task automatic model_write(input logic [3:0] a, input logic [7:0] d, input bit allow);
    int k;
    k = int'(a) / 2;
    if (k < 6) m_row[k] = d % 32;
    else if (allow && k == 6) begin m_mode = d; m_ptr = 0; end
    else if (allow && k == 7) begin m_tile[m_ptr] = d; m_ptr = (m_ptr + 1) % 4; end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d, rop_allow);
  endtask

  task automatic check_all(input string ctx);
    logic [4:0] outs [6];
    outs[0] = first_start;  outs[1] = first_end;   outs[2] = blank_line;
    outs[3] = scroll_lines; outs[4] = scroll_base; outs[5] = scroll_span;
    for (int i = 0; i < 6; i++)
      expect_eq("R2", $sformatf("%s row%0d out", ctx, i), 16'(outs[i]), 16'(m_row[i]));
    expect_eq("R5", {ctx, " mode"}, 16'(rop_mode), 16'(m_mode));
    expect_eq("R5", {ctx, " op"}, 16'(rop_op), 16'(m_mode / 64));
    for (int i = 0; i < 4; i++)
      expect_eq("R7", $sformatf("%s tile%0d", ctx, i), tile_slots[i*16 +: 16],
                16'(m_tile[i]) * 16'd257);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #0.1;
      if (a / 2 < 6)
        expect_eq("R3", $sformatf("%s rd ofs %0h (R9 alias)", ctx, a), 16'(rdata),
                  16'(m_row[a / 2]));
      else
        expect_eq("R4", $sformatf("%s rd ofs %0h", ctx, a), 16'(rdata), 16'h00FF);
    end
  endtask

  initial begin
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h1F; pats[5] = 8'hE0;
    rst = 1'b1; rop_allow = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // Sweep with raster-op writes allowed; R10 isolation is checked by check_all
    for (int a = 0; a < 16; a++)
      for (int p = 0; p < 6; p++) begin
        bus_write(4'(a), pats[p] ^ 8'(a * 17));
        check_all("R10 allowed sweep");
      end

    // R6 rewind in the middle of a pass, then R7 wrap
    bus_write(4'hE, 8'h11);
    bus_write(4'hF, 8'h22);
    bus_write(4'hC, 8'h40);
    check_all("R6 rewind");
    for (int t = 0; t < 9; t++) begin
      bus_write(4'hE, 8'(8'h30 + t));
      check_all("R7 wrap");
    end

    // R8: gated sweep, mode and tile writes ignored
    rop_allow = 1'b0;
    for (int a = 0; a < 16; a++)
      for (int p = 0; p < 6; p++) begin
        bus_write(4'(a), pats[p] ^ 8'(a * 29));
        check_all("R8 gated sweep");
      end
    // Pointer unaffected by gated mode write: next allowed tile continues
    rop_allow = 1'b1;
    bus_write(4'hE, 8'h9C);
    check_all("R8 pointer kept");

    // Reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    check_all("R1 second reset");

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule